// File: doc/BRIEF.md
# Port Control Register Window

This block is a bank of control and status registers that a host reaches over a simple synchronous 8-bit bus. It decodes a 256-byte window whose upper address bits are set by the `base_page` input. The window holds registers for three 8-bit general-purpose ports, two banks of output-macrocell registers guarded by per-bit masks, a page register, two power-management registers and a JTAG-enable register. It also holds read-only protection, security and memory-size identification values, which come from parameters.

The pins of each port are controlled from the window. The direction register sets the output enables, and the data-out register sets the levels the pins drive. The host reads back the pin levels, the input-macrocell state and the output-enable status. The output-macrocell banks can only be written or read through their masks. A set mask bit protects that bit from writes and hides it from reads. Every location in the window that has no register reads as zero. Writes to those locations do nothing.

Top module: `port_ctl_regs`

## Requirements
- R1: An access takes effect only when `cs` is high and `addr[15:8]` equals `base_page`. Any other write changes no register, and any other read returns zero on `rdata`.
- R2: While reset is held, and after it is released, every read/write register is zero. So `pad_oe`, `pad_out`, `drive_sel`, `mc_a`, `mc_b`, `page`, `pm0`, `pm2` and `jtag_en` are all zero.
- R3: Each port has a direction register. A bit of 1 makes that pin an output and drives its `pad_oe` bit high. The register reads back what was written. The enable-status register returns the same bits.
- R4: Each port has a data-out register. It drives `pad_out`, and a read returns the last value written.
- R5: Reading a port's data-in register returns the current `pad_in` byte of that port. Reading its input-macrocell register returns the `imc_in` byte of that port.
- R6: The port register offsets within the window are fixed:
  - Port 0: data-in 0x00, data-out 0x04, direction 0x06, drive 0x08, input-macrocell 0x0A, enable-status 0x0C.
  - Port 1: the same offsets plus 0x01.
  - Port 2: the same offsets plus 0x10.
- R7: Macrocell bank A is at 0x20 and bank B at 0x21. A write to a bank changes only the bits whose mask bit is 0. Bits whose mask bit is 1 keep their previous value. `mc_a` and `mc_b` show the full register contents.
- R8: A read of a macrocell bank returns 0 in every bit whose mask bit is 1. Bank A's mask is at 0x22 and bank B's mask at 0x23, and both masks read back as written.
- R9: These registers are read/write and each drives the output named beside it:
  - drive select (per port) drives `drive_sel`
  - power-management 0 at 0xB0 drives `pm0`
  - power-management 2 at 0xB4 drives `pm2`
  - JTAG enable at 0xC7 drives `jtag_en`
  - page at 0xE0 drives `page`
- R10: The read-only registers return their parameter values, and writes to them have no effect:
  - protection at 0xC0
  - security at 0xC2
  - memory-size identifiers at 0xF0 and 0xF1
  - data-in, input-macrocell and enable-status of each port
- R11: Locations in the window that hold no register read as zero. Writes to them change no output or register.
- R12: `rdata` is registered. It shows the addressed value in the cycle after a cycle with `rd` high, and zero after every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_page | input | 8 | Upper address bits that place the window |
| cs | input | 1 | Chip select for the host bus |
| addr | input | 16 | Host byte address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 24 | Pin levels of ports 0..2 (port 0 in bits 7:0) |
| imc_in | input | 24 | Input-macrocell state of ports 0..2 |
| pad_out | output | 24 | Output levels from the data-out registers |
| pad_oe | output | 24 | Output enables from the direction registers |
| drive_sel | output | 24 | Drive-select register contents |
| mc_a | output | 8 | Macrocell bank A contents |
| mc_b | output | 8 | Macrocell bank B contents |
| page | output | 8 | Page register |
| pm0 | output | 8 | Power-management register 0 |
| pm2 | output | 8 | Power-management register 2 |
| jtag_en | output | 8 | JTAG enable register |

## Verification
Each port gets a distinct direction and data pattern, so any crossing of port offsets shows up as a wrong byte on a neighbour's pins. The macrocell masks are tried as a nibble split, then inverted, then all-ones. This separates a correct hold-on-masked-write from an overwrite and from a mask that was only applied on read. Accesses in another page and with chip select low are sent with the same offsets as real registers, which shows that the window compare matters. A sweep over all 256 offsets compares the read data against a behavioural model every cycle, which catches any stray decode in the unused locations.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int DW = 8;

    // per-port offsets (port 0), shifted by the port bias
    localparam logic [7:0] OFF_DIN  = 8'h00;
    localparam logic [7:0] OFF_DOUT = 8'h04;
    localparam logic [7:0] OFF_DIR  = 8'h06;
    localparam logic [7:0] OFF_DRV  = 8'h08;
    localparam logic [7:0] OFF_IMC  = 8'h0A;
    localparam logic [7:0] OFF_OEN  = 8'h0C;

    // shared registers
    localparam logic [7:0] OFF_MCA  = 8'h20;
    localparam logic [7:0] OFF_MCB  = 8'h21;
    localparam logic [7:0] OFF_MSKA = 8'h22;
    localparam logic [7:0] OFF_MSKB = 8'h23;
    localparam logic [7:0] OFF_PM0  = 8'hB0;
    localparam logic [7:0] OFF_PM2  = 8'hB4;
    localparam logic [7:0] OFF_PROT = 8'hC0;
    localparam logic [7:0] OFF_SEC  = 8'hC2;
    localparam logic [7:0] OFF_JTAG = 8'hC7;
    localparam logic [7:0] OFF_PAGE = 8'hE0;
    localparam logic [7:0] OFF_ID0  = 8'hF0;
    localparam logic [7:0] OFF_ID1  = 8'hF1;

    function automatic logic [7:0] port_bias(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h01;
            default: return 8'h10;
        endcase
    endfunction

    typedef struct packed {
        logic [DW-1:0] dout;
        logic [DW-1:0] dir;
        logic [DW-1:0] drv;
    } port_regs_t;

    typedef struct packed {
        logic [DW-1:0] val;
        logic [DW-1:0] msk;
    } mc_regs_t;

    typedef struct packed {
        logic [DW-1:0] pm0;
        logic [DW-1:0] pm2;
        logic [DW-1:0] page;
        logic [DW-1:0] jtag;
        logic [DW-1:0] rdata;
    } misc_regs_t;

endpackage

// File: rtl/pcr_window.sv
module pcr_window #(
    parameter int ADDR_W = 16
) (
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-9:0] base_page,
    output logic              hit,
    output logic [7:0]        off
);
    always_comb begin
        hit = cs && (addr[ADDR_W-1:8] == base_page);
        off = addr[7:0];
    end
endmodule

// File: rtl/pcr_port.sv
module pcr_port
    import pcr_pkg::*;
#(
    parameter logic [7:0] BIAS = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    off,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_lvl,
    input  logic [DW-1:0] imc_lvl,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] dir,
    output logic [DW-1:0] drv,
    output logic [DW-1:0] rval
);
    localparam logic [7:0] A_DIN  = OFF_DIN  + BIAS;
    localparam logic [7:0] A_DOUT = OFF_DOUT + BIAS;
    localparam logic [7:0] A_DIR  = OFF_DIR  + BIAS;
    localparam logic [7:0] A_DRV  = OFF_DRV  + BIAS;
    localparam logic [7:0] A_IMC  = OFF_IMC  + BIAS;
    localparam logic [7:0] A_OEN  = OFF_OEN  + BIAS;

    port_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (off)
                A_DOUT:  r_d.dout = wdata;
                A_DIR:   r_d.dir  = wdata;
                A_DRV:   r_d.drv  = wdata;
                default: ;
            endcase
        end
        case (off)
            A_DIN:   rval = pin_lvl;
            A_DOUT:  rval = r_q.dout;
            A_DIR:   rval = r_q.dir;
            A_DRV:   rval = r_q.drv;
            A_IMC:   rval = imc_lvl;
            A_OEN:   rval = r_q.dir;
            default: rval = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout = r_q.dout;
    assign dir  = r_q.dir;
    assign drv  = r_q.drv;
endmodule

// File: rtl/pcr_mcbank.sv
module pcr_mcbank
    import pcr_pkg::*;
#(
    parameter logic [7:0] A_VAL = 8'h20,
    parameter logic [7:0] A_MSK = 8'h22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] val,
    output logic [DW-1:0] msk,
    output logic [DW-1:0] rval
);
    mc_regs_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we && off == A_VAL) m_d.val = (m_q.val & m_q.msk) | (wdata & ~m_q.msk);
        if (we && off == A_MSK) m_d.msk = wdata;
        if (off == A_VAL)      rval = m_q.val & ~m_q.msk;
        else if (off == A_MSK) rval = m_q.msk;
        else                   rval = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign val = m_q.val;
    assign msk = m_q.msk;
endmodule

// File: rtl/port_ctl_regs.sv
module port_ctl_regs
    import pcr_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         NPORT    = 3,
    parameter logic [7:0] PROT_VAL = 8'h0F,
    parameter logic [7:0] SEC_VAL  = 8'h01,
    parameter logic [7:0] ID0_VAL  = 8'h25,
    parameter logic [7:0] ID1_VAL  = 8'h13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-9:0]   base_page,
    input  logic                cs,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                rd,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic [NPORT*DW-1:0] pad_in,
    input  logic [NPORT*DW-1:0] imc_in,
    output logic [NPORT*DW-1:0] pad_out,
    output logic [NPORT*DW-1:0] pad_oe,
    output logic [NPORT*DW-1:0] drive_sel,
    output logic [DW-1:0]       mc_a,
    output logic [DW-1:0]       mc_b,
    output logic [DW-1:0]       page,
    output logic [DW-1:0]       pm0,
    output logic [DW-1:0]       pm2,
    output logic [DW-1:0]       jtag_en
);
    localparam int NBANK = 2;

    logic          hit, we, re;
    logic [7:0]    off;
    logic [DW-1:0] port_rv [NPORT];
    logic [DW-1:0] bank_rv [NBANK];
    logic [DW-1:0] bank_val [NBANK];
    logic [DW-1:0] bank_msk [NBANK];
    logic [DW-1:0] msk_a;
    logic [DW-1:0] rd_val;
    misc_regs_t    s_d, s_q;

    pcr_window #(.ADDR_W(ADDR_W)) u_win (
        .cs(cs), .addr(addr), .base_page(base_page), .hit(hit), .off(off)
    );

    assign we = hit && wr;
    assign re = hit && rd;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pcr_port #(.BIAS(port_bias(p))) u_port (
            .clk(clk), .rst_n(rst_n), .we(we), .off(off), .wdata(wdata),
            .pin_lvl(pad_in[p*DW +: DW]), .imc_lvl(imc_in[p*DW +: DW]),
            .dout(pad_out[p*DW +: DW]), .dir(pad_oe[p*DW +: DW]),
            .drv(drive_sel[p*DW +: DW]), .rval(port_rv[p])
        );
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        pcr_mcbank #(
            .A_VAL(b == 0 ? OFF_MCA  : OFF_MCB),
            .A_MSK(b == 0 ? OFF_MSKA : OFF_MSKB)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .we(we), .off(off), .wdata(wdata),
            .val(bank_val[b]), .msk(bank_msk[b]), .rval(bank_rv[b])
        );
    end

    always_comb begin
        s_d = s_q;
        if (we) begin
            case (off)
                OFF_PM0:  s_d.pm0  = wdata;
                OFF_PM2:  s_d.pm2  = wdata;
                OFF_PAGE: s_d.page = wdata;
                OFF_JTAG: s_d.jtag = wdata;
                default:  ;
            endcase
        end
        case (off)
            OFF_PM0:  rd_val = s_q.pm0;
            OFF_PM2:  rd_val = s_q.pm2;
            OFF_PAGE: rd_val = s_q.page;
            OFF_JTAG: rd_val = s_q.jtag;
            OFF_PROT: rd_val = PROT_VAL;
            OFF_SEC:  rd_val = SEC_VAL;
            OFF_ID0:  rd_val = ID0_VAL;
            OFF_ID1:  rd_val = ID1_VAL;
            default:  rd_val = '0;
        endcase
        for (int p = 0; p < NPORT; p++) rd_val = rd_val | port_rv[p];
        for (int b = 0; b < NBANK; b++) rd_val = rd_val | bank_rv[b];
        s_d.rdata = re ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata   = s_q.rdata;
    assign pm0     = s_q.pm0;
    assign pm2     = s_q.pm2;
    assign page    = s_q.page;
    assign jtag_en = s_q.jtag;
    assign mc_a    = bank_val[0];
    assign mc_b    = bank_val[1];
    assign msk_a   = bank_msk[0];

endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-9:0] base_page,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [7:0]        pad_out0,
    input logic [7:0]        pad_oe0,
    input logic [7:0]        mc_a,
    input logic [7:0]        msk_a,
    input logic [7:0]        page
);
    logic in_win;
    assign in_win = cs && (addr[ADDR_W-1:8] == base_page);

    a_r1_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !in_win) |=> (rdata == 8'h00));

    a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |=> (rdata == 8'h00));

    a_r3_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && wr && addr[7:0] == 8'h06) |=> (pad_oe0 == $past(wdata)));

    a_r4_dout_drives_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && wr && addr[7:0] == 8'h04) |=> (pad_out0 == $past(wdata)));

    a_r7_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && wr && addr[7:0] == 8'h20)
        |=> ((mc_a & $past(msk_a)) == ($past(mc_a) & $past(msk_a))));

    a_r9_page_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && wr && addr[7:0] == 8'hE0) |=> (page == $past(wdata)));
endmodule

bind port_ctl_regs pcr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .base_page(base_page), .wdata(wdata), .rdata(rdata),
    .pad_out0(pad_out[7:0]), .pad_oe0(pad_oe[7:0]),
    .mc_a(mc_a), .msk_a(msk_a), .page(page)
);

// File: tb/port_ctl_regs_test.sv
module port_ctl_regs_test;
    localparam logic [7:0] PROT = 8'h5A;
    localparam logic [7:0] SEC  = 8'h81;
    localparam logic [7:0] ID0  = 8'h33;
    localparam logic [7:0] ID1  = 8'hC4;
    localparam logic [7:0] BASE = 8'h12;

    logic        clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0;
    logic [7:0]  base_page = BASE, wdata = 0;
    logic [15:0] addr = 0;
    logic [23:0] pad_in = 0, imc_in = 0;
    logic [7:0]  rdata, mc_a, mc_b, page, pm0, pm2, jtag_en;
    logic [23:0] pad_out, pad_oe, drive_sel;

    int checks = 0, errors = 0;
    bit done = 0, primed = 0;

    always #4 clk = ~clk;

    port_ctl_regs #(.PROT_VAL(PROT), .SEC_VAL(SEC), .ID0_VAL(ID0), .ID1_VAL(ID1)) uut (
        .clk(clk), .rst_n(rst_n), .base_page(base_page), .cs(cs), .addr(addr),
        .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
        .imc_in(imc_in), .pad_out(pad_out), .pad_oe(pad_oe), .drive_sel(drive_sel),
        .mc_a(mc_a), .mc_b(mc_b), .page(page), .pm0(pm0), .pm2(pm2), .jtag_en(jtag_en)
    );

    // behavioural reference model
    logic [7:0] m_dout [3], m_dir [3], m_drv [3];
    logic [7:0] m_mca, m_mcb, m_mka, m_mkb, m_pm0, m_pm2, m_page, m_jtag, m_rdata;

    function automatic logic [7:0] bias(int p);
        return (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : 8'h10;
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] o);
        for (int p = 0; p < 3; p++) begin
            if (o == 8'h00 + bias(p)) return pad_in[p*8 +: 8];
            if (o == 8'h04 + bias(p)) return m_dout[p];
            if (o == 8'h06 + bias(p)) return m_dir[p];
            if (o == 8'h08 + bias(p)) return m_drv[p];
            if (o == 8'h0A + bias(p)) return imc_in[p*8 +: 8];
            if (o == 8'h0C + bias(p)) return m_dir[p];
        end
        case (o)
            8'h20: return m_mca & ~m_mka;
            8'h21: return m_mcb & ~m_mkb;
            8'h22: return m_mka;
            8'h23: return m_mkb;
            8'hB0: return m_pm0;
            8'hB4: return m_pm2;
            8'hC0: return PROT;
            8'hC2: return SEC;
            8'hC7: return m_jtag;
            8'hE0: return m_page;
            8'hF0: return ID0;
            8'hF1: return ID1;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) begin m_dout[p] = 0; m_dir[p] = 0; m_drv[p] = 0; end
            {m_mca, m_mcb, m_mka, m_mkb, m_pm0, m_pm2, m_page, m_jtag, m_rdata} = '0;
        end else begin
            bit h;
            logic [7:0] o;
            h = cs && (addr[15:8] == base_page);
            o = addr[7:0];
            m_rdata = (h && rd) ? m_read(o) : 8'h00;
            if (h && wr) begin
                for (int p = 0; p < 3; p++) begin
                    if (o == 8'h04 + bias(p)) m_dout[p] = wdata;
                    if (o == 8'h06 + bias(p)) m_dir[p]  = wdata;
                    if (o == 8'h08 + bias(p)) m_drv[p]  = wdata;
                end
                case (o)
                    8'h20: m_mca = (m_mca & m_mka) | (wdata & ~m_mka);
                    8'h21: m_mcb = (m_mcb & m_mkb) | (wdata & ~m_mkb);
                    8'h22: m_mka = wdata;
                    8'h23: m_mkb = wdata;
                    8'hB0: m_pm0 = wdata;
                    8'hB4: m_pm2 = wdata;
                    8'hC7: m_jtag = wdata;
                    8'hE0: m_page = wdata;
                    default: ;
                endcase
            end
        end
        primed = 1;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) if (primed) begin
        chk("R12 rdata vs model", {24'h0, rdata}, {24'h0, m_rdata});
        chk("R4 pad_out", {8'h0, pad_out}, {8'h0, m_dout[2], m_dout[1], m_dout[0]});
        chk("R3 pad_oe", {8'h0, pad_oe}, {8'h0, m_dir[2], m_dir[1], m_dir[0]});
        chk("R9 drive_sel", {8'h0, drive_sel}, {8'h0, m_drv[2], m_drv[1], m_drv[0]});
        chk("R7 mc outputs", {16'h0, mc_a, mc_b}, {16'h0, m_mca, m_mcb});
        chk("R9 misc outputs", {page, pm0, pm2, jtag_en}, {m_page, m_pm0, m_pm2, m_jtag});
    end

    task automatic bwr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic brd(logic [15:0] a, logic [7:0] exp, string tag);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        @(negedge clk); cs = 0; rd = 0;
        chk(tag, {24'h0, rdata}, {24'h0, exp});
    endtask

    function automatic logic [15:0] w(logic [7:0] o);
        return {BASE, o};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 pad_oe after reset", {8'h0, pad_oe}, 32'h0);
        chk("R2 pad_out after reset", {8'h0, pad_out}, 32'h0);
        rst_n = 1;
        brd(w(8'h06), 8'h00, "R2 dir reads zero");
        brd(w(8'h20), 8'h00, "R2 bank A reads zero");

        // R3/R6: direction per port
        bwr(w(8'h06), 8'hA5); bwr(w(8'h07), 8'h3C); bwr(w(8'h16), 8'hFF);
        chk("R3 R6 oe per port", {8'h0, pad_oe}, 32'h00FF3CA5);
        brd(w(8'h07), 8'h3C, "R3 dir readback port1");
        brd(w(8'h1C), 8'hFF, "R3 enable-status port2");

        // R4: data out
        bwr(w(8'h04), 8'h11); bwr(w(8'h05), 8'h22); bwr(w(8'h14), 8'h44);
        chk("R4 R6 pad_out per port", {8'h0, pad_out}, 32'h00442211);
        brd(w(8'h14), 8'h44, "R4 dout readback port2");

        // R5: pin and macrocell inputs
        pad_in = 24'h9C_5B_E1; imc_in = 24'h07_70_AA;
        brd(w(8'h00), 8'hE1, "R5 din port0");
        brd(w(8'h01), 8'h5B, "R5 din port1");
        brd(w(8'h1A), 8'h07, "R5 imc port2");
        brd(w(8'h0A), 8'hAA, "R5 imc port0");

        // R10: read-only registers ignore writes
        bwr(w(8'hF0), 8'h00); bwr(w(8'hC0), 8'hFF); bwr(w(8'h10), 8'h77);
        brd(w(8'hF0), ID0, "R10 id0");
        brd(w(8'hF1), ID1, "R10 id1");
        brd(w(8'hC0), PROT, "R10 protection");
        brd(w(8'hC2), SEC, "R10 security");
        brd(w(8'h10), 8'h9C, "R10 din write ignored");

        // R7/R8: masked macrocell banks
        bwr(w(8'h22), 8'h0F); bwr(w(8'h20), 8'hFF);
        chk("R7 mask holds low nibble", {24'h0, mc_a}, 32'hF0);
        brd(w(8'h20), 8'hF0, "R8 read masked bank A");
        bwr(w(8'h22), 8'hF0); bwr(w(8'h20), 8'h00);
        chk("R7 inverted mask holds high", {24'h0, mc_a}, 32'hF0);
        brd(w(8'h20), 8'h00, "R8 masked high reads zero");
        brd(w(8'h22), 8'hF0, "R8 mask readback");
        bwr(w(8'h23), 8'hFF); bwr(w(8'h21), 8'hFF);
        chk("R7 full mask blocks bank B", {24'h0, mc_b}, 32'h0);
        bwr(w(8'h23), 8'h00); bwr(w(8'h21), 8'h6D);
        brd(w(8'h21), 8'h6D, "R8 bank B open mask");

        // R9: control registers
        bwr(w(8'hE0), 8'h03); bwr(w(8'hB0), 8'h81); bwr(w(8'hB4), 8'h42);
        bwr(w(8'hC7), 8'h01); bwr(w(8'h18), 8'hC3);
        brd(w(8'hE0), 8'h03, "R9 page");
        brd(w(8'hB4), 8'h42, "R9 pm2");
        brd(w(8'h18), 8'hC3, "R9 drive port2");

        // R11: unused locations
        bwr(w(8'h05 + 8'h30), 8'hAA); bwr(w(8'hFF), 8'h55); bwr(w(8'h24), 8'h99);
        brd(w(8'h35), 8'h00, "R11 unused 0x35");
        brd(w(8'hFF), 8'h00, "R11 unused 0xFF");
        chk("R11 outputs unchanged", {page, pm0, pm2, jtag_en}, 32'h03814201);

        // R1: outside window and chip select low
        bwr(16'h3406, 8'h00);
        chk("R1 other page write ignored", {8'h0, pad_oe}, 32'h00FF3CA5);
        brd(16'h34F0, 8'h00, "R1 other page read zero");
        @(negedge clk); cs = 0; wr = 1; addr = w(8'hE0); wdata = 8'hEE;
        @(negedge clk); wr = 0;
        chk("R1 cs low write ignored", {24'h0, page}, 32'h03);
        base_page = 8'h34;
        brd(16'h34F0, ID0, "R1 moved window");
        base_page = BASE;

        // R12/R11: sweep every offset against the model
        for (int o = 0; o < 256; o++) begin
            @(negedge clk); cs = 1; rd = 1; addr = w(o[7:0]);
        end
        @(negedge clk); cs = 0; rd = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog act=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule